// File: doc/BRIEF.md
# ADC Sequence Status Register

This block keeps the status byte of a multi-channel analog-to-digital conversion sequencer. The byte holds three sticky flags and a 4-bit conversion counter. The first flag marks a finished sequence. The second marks a trigger edge that arrived too early. The third marks a result FIFO overrun. The conversion controller reports events on single-cycle pulse inputs, and those pulses set the flags. Software clears the flags through a small register bus. A flag can be cleared by writing 1 to its own bit, or as a side effect of other register accesses that the block decodes from the bus address.

Each flag has its own set and clear paths. When a set event and a clear event arrive in the same cycle, the set wins, so no event is lost. The counter advances once per completed conversion. It wraps at the programmed sequence length, and it returns to zero whenever a sequence is started or aborted. Reads are combinational: `rdata_o` shows the status byte whenever the address selects the status register, and shows zero for any other address.

Top module: `adc_seq_status`

## Requirements
- R1: After reset, the status byte reads 0x00. Its layout is: bit 7 = sequence-complete flag, bit 6 = reserved (always reads 0), bit 5 = trigger overrun flag, bit 4 = FIFO overrun flag, bits 3:0 = conversion counter. The status register is at address 6.
- R2: A pulse on `seq_done_i` sets the sequence-complete flag in the next cycle. In continuous operation this happens again at the end of every sequence.
- R3: A status write with bit 7 = 1 clears the sequence-complete flag. A status write with bit 7 = 0 leaves the flag unchanged.
- R4: Any write to the start register (address 5) clears the sequence-complete flag.
- R5: While `fast_clr_i` = 1, a read (`rd_en_i` = 1) of a result address (8 to 15) clears the sequence-complete flag. While `fast_clr_i` = 0, such a read has no effect.
- R6: The trigger overrun flag is set only when three conditions hold in the same cycle: `trig_edge_i` = 1, `edge_mode_i` = 1 and `seq_busy_i` = 1.
- R7: The trigger overrun flag is cleared by any of three writes: a status write with bit 5 = 1, a write to a control address (0 to 4), or a write to the start register.
- R8: A pulse on `fifo_ovr_i` sets the FIFO overrun flag. The flag is cleared by a status write with bit 4 = 1, or by a write to the start register.
- R9: A status write never changes the counter bits or bit 6. Writing 0 to a flag bit has no effect on that flag.
- R10: The counter increments on each `conv_done_i` pulse and wraps to 0 after reaching `seq_len_i` − 1. A `seq_len_i` value of 0 means a length of 16.
- R11: A write to a control address (0 to 4) or to the start register resets the counter to 0. This reset takes priority over `conv_done_i` in the same cycle.
- R12: When a set event and a clear event for the same flag occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Register bus address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data: the status byte when the status address is selected, otherwise 0 |
| fast_clr_i | input | 1 | Enables clearing of the sequence-complete flag on result reads |
| edge_mode_i | input | 1 | Edge-trigger mode is active |
| seq_len_i | input | 4 | Sequence length (0 means 16) |
| seq_busy_i | input | 1 | A sequence is currently running |
| seq_done_i | input | 1 | A sequence completed (one-cycle pulse) |
| conv_done_i | input | 1 | A conversion completed (one-cycle pulse) |
| trig_edge_i | input | 1 | An active external trigger edge was seen (one-cycle pulse) |
| fifo_ovr_i | input | 1 | A result FIFO overrun occurred (one-cycle pulse) |

## Verification
The bench uses the default parameters: a 4-bit address, control registers at 0 to 4, start at 5, status at 6, and eight result addresses from 8 to 15. With this map, random addresses land on every access type, including unmapped address 7. A sequence length of 0 drives the counter through its full 16-value wrap, and a length of 3 exercises a short wrap. Directed cycles pair set and clear events in the same cycle. The random phase toggles the fast-clear and edge-mode controls so that each conditional clear or set path is reached both enabled and disabled.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;
  localparam int CNT_W   = 4;
  localparam int BYTE_W  = 8;
  localparam int FLAG_N  = 3;
  // bit positions in the status byte (software decodes these)
  localparam int SEQ_BIT = 7;
  localparam int RSV_BIT = 6;
  localparam int TRG_BIT = 5;
  localparam int FOV_BIT = 4;
  // flag indices inside the flag vector
  localparam int F_SEQ = 0;
  localparam int F_TRG = 1;
  localparam int F_FOV = 2;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_CTRL,
    ACC_START,
    ACC_STAT,
    ACC_RES
  } acc_kind_e;
endpackage

// File: rtl/adc_stat_decode.sv
module adc_stat_decode
  import adc_stat_pkg::*;
#(
  parameter int AW         = 4,
  parameter int CTRL_NUM   = 5,
  parameter int START_ADDR = 5,
  parameter int STAT_ADDR  = 6,
  parameter int RES_BASE   = 8,
  parameter int RES_NUM    = 8
) (
  input  logic [AW-1:0] addr_i,
  output acc_kind_e     kind_o
);
  localparam logic [AW:0] CTRL_END = (AW+1)'(CTRL_NUM);
  localparam logic [AW:0] START_A  = (AW+1)'(START_ADDR);
  localparam logic [AW:0] STAT_A   = (AW+1)'(STAT_ADDR);
  localparam logic [AW:0] RES_LO   = (AW+1)'(RES_BASE);
  localparam logic [AW:0] RES_HI   = (AW+1)'(RES_BASE + RES_NUM);

  logic [AW:0] a_ext;
  assign a_ext = {1'b0, addr_i};

  always_comb begin
    kind_o = ACC_NONE;
    if (a_ext < CTRL_END)                        kind_o = ACC_CTRL;
    else if (a_ext == START_A)                   kind_o = ACC_START;
    else if (a_ext == STAT_A)                    kind_o = ACC_STAT;
    else if (a_ext >= RES_LO && a_ext < RES_HI)  kind_o = ACC_RES;
  end
endmodule

// File: rtl/adc_stat_flag.sv
module adc_stat_flag #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q <= 1'b0;
      else if (set_i[i])  q <= 1'b1;   // set beats clear
      else if (clr_i[i])  q <= 1'b0;
    end
    assign flag_o[i] = q;
  end
endmodule

// File: rtl/adc_stat_counter.sv
module adc_stat_counter #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] len_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, last;

  assign last = len_i - W'(1);  // len 0 -> all ones -> full range

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (inc_i) begin
      if (cnt_q >= last)    cnt_q <= '0;
      else                  cnt_q <= cnt_q + W'(1);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/adc_seq_status.sv
module adc_seq_status
  import adc_stat_pkg::*;
#(
  parameter int AW         = 4,
  parameter int CTRL_NUM   = 5,
  parameter int START_ADDR = 5,
  parameter int STAT_ADDR  = 6,
  parameter int RES_BASE   = 8,
  parameter int RES_NUM    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              fast_clr_i,
  input  logic              edge_mode_i,
  input  logic [CNT_W-1:0]  seq_len_i,
  input  logic              seq_busy_i,
  input  logic              seq_done_i,
  input  logic              conv_done_i,
  input  logic              trig_edge_i,
  input  logic              fifo_ovr_i
);
  acc_kind_e         kind;
  logic              wr_ctrl, wr_start, wr_stat, rd_res;
  logic [FLAG_N-1:0] f_set, f_clr, flags;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] stat_w;

  adc_stat_decode #(
    .AW(AW), .CTRL_NUM(CTRL_NUM), .START_ADDR(START_ADDR),
    .STAT_ADDR(STAT_ADDR), .RES_BASE(RES_BASE), .RES_NUM(RES_NUM)
  ) u_dec (
    .addr_i (addr_i),
    .kind_o (kind)
  );

  assign wr_ctrl  = wr_en_i && (kind == ACC_CTRL);
  assign wr_start = wr_en_i && (kind == ACC_START);
  assign wr_stat  = wr_en_i && (kind == ACC_STAT);
  assign rd_res   = rd_en_i && (kind == ACC_RES) && fast_clr_i;

  always_comb begin
    f_set = '0;
    f_clr = '0;
    f_set[F_SEQ] = seq_done_i;
    f_clr[F_SEQ] = (wr_stat && wdata_i[SEQ_BIT]) || wr_start || rd_res;
    f_set[F_TRG] = trig_edge_i && edge_mode_i && seq_busy_i;
    f_clr[F_TRG] = (wr_stat && wdata_i[TRG_BIT]) || wr_ctrl || wr_start;
    f_set[F_FOV] = fifo_ovr_i;
    f_clr[F_FOV] = (wr_stat && wdata_i[FOV_BIT]) || wr_start;
  end

  adc_stat_flag #(.N(FLAG_N)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (f_set),
    .clr_i  (f_clr),
    .flag_o (flags)
  );

  adc_stat_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wr_ctrl || wr_start),
    .inc_i  (conv_done_i),
    .len_i  (seq_len_i),
    .cnt_o  (cnt)
  );

  always_comb begin
    stat_w            = '0;
    stat_w[SEQ_BIT]   = flags[F_SEQ];
    stat_w[RSV_BIT]   = 1'b0;
    stat_w[TRG_BIT]   = flags[F_TRG];
    stat_w[FOV_BIT]   = flags[F_FOV];
    stat_w[CNT_W-1:0] = cnt;
  end

  assign rdata_o = (kind == ACC_STAT) ? stat_w : '0;
endmodule

// File: rtl/adc_seq_status_chk.sv
module adc_seq_status_chk #(
  parameter int AW         = 4,
  parameter int CTRL_NUM   = 5,
  parameter int START_ADDR = 5,
  parameter int STAT_ADDR  = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          wr_en_i,
  input logic [7:0]    wdata_i,
  input logic          edge_mode_i,
  input logic          seq_done_i,
  input logic          conv_done_i,
  input logic          fifo_ovr_i,
  input logic [7:0]    stat_i
);
  logic is_ctrl, is_start, is_stat;
  assign is_ctrl  = ({1'b0, addr_i} < (AW+1)'(CTRL_NUM));
  assign is_start = (addr_i == AW'(START_ADDR));
  assign is_stat  = (addr_i == AW'(STAT_ADDR));

  AST_SEQ_DONE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_i |=> stat_i[7]);  // R2

  AST_START_CLEARS_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && is_start && !seq_done_i) |=> !stat_i[7]);  // R4

  AST_LEVEL_MODE_NO_TRG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && !stat_i[5]) |=> !stat_i[5]);  // R6

  AST_FIFO_OVR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_ovr_i |=> stat_i[4]);  // R8

  AST_STAT_WR_KEEPS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && is_stat && !conv_done_i) |=> $stable(stat_i[3:0]));  // R9

  AST_ABORT_ZEROES_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (is_ctrl || is_start)) |=> (stat_i[3:0] == 4'd0));  // R11
endmodule

bind adc_seq_status adc_seq_status_chk #(
  .AW(AW), .CTRL_NUM(CTRL_NUM), .START_ADDR(START_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wr_en_i     (wr_en_i),
  .wdata_i     (wdata_i),
  .edge_mode_i (edge_mode_i),
  .seq_done_i  (seq_done_i),
  .conv_done_i (conv_done_i),
  .fifo_ovr_i  (fifo_ovr_i),
  .stat_i      (stat_w)
);

// File: tb/adc_seq_status_test.sv
module adc_seq_status_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = 4'd6;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       fast = 1'b0, edge_m = 1'b0, busy = 1'b0;
  logic [3:0] slen = 4'd0;
  logic       sd = 1'b0, cd = 1'b0, te = 1'b0, fo = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit m_seq = 0, m_trg = 0, m_fov = 0;
  int m_cnt = 0;

  always #5 clk = ~clk;

  adc_seq_status uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata),
    .rd_en_i(rd), .rdata_o(rdata), .fast_clr_i(fast), .edge_mode_i(edge_m),
    .seq_len_i(slen), .seq_busy_i(busy), .seq_done_i(sd), .conv_done_i(cd),
    .trig_edge_i(te), .fifo_ovr_i(fo)
  );

  task automatic check(string tag);
    logic [7:0] exp;
    addr = 4'd6; wr = 0; rd = 0; sd = 0; cd = 0; te = 0; fo = 0;
    #1;
    exp = {m_seq, 1'b0, m_trg, m_fov, 4'(m_cnt)};
    n_chk++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: status got %02h expected %02h", tag, rdata, exp);
    end
  endtask

  // drive one cycle, advance the model at the edge, then check
  task automatic step(input logic [3:0] a, input logic w, input logic [7:0] d,
                      input logic r, input logic s_d, input logic c_d,
                      input logic t_e, input logic f_o, input string tag);
    bit start, abort, swr, rres, len;
    int l;
    addr = a; wr = w; wdata = d; rd = r; sd = s_d; cd = c_d; te = t_e; fo = f_o;
    @(posedge clk);
    start = w && (a == 4'd5);
    abort = w && (a <= 4'd4);
    swr   = w && (a == 4'd6);
    rres  = r && (a >= 4'd8) && fast;
    if (s_d) m_seq = 1;
    else if ((swr && d[7]) || start || rres) m_seq = 0;
    if (t_e && edge_m && busy) m_trg = 1;
    else if ((swr && d[5]) || abort || start) m_trg = 0;
    if (f_o) m_fov = 1;
    else if ((swr && d[4]) || start) m_fov = 0;
    l = (slen == 0) ? 16 : int'(slen);
    if (start || abort) m_cnt = 0;
    else if (c_d) m_cnt = (m_cnt + 1 >= l) ? 0 : m_cnt + 1;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    step(4'd0, 0, 8'h00, 0, 1, 0, 0, 0, "R2 seq done sets");
    step(4'd6, 1, 8'h7F, 0, 0, 0, 0, 0, "R3 write 0 to bit7 ignored");
    step(4'd6, 1, 8'h80, 0, 0, 0, 0, 0, "R3 w1 clears");
    step(4'd0, 0, 8'h00, 0, 1, 0, 0, 0, "R2 set again");
    step(4'd6, 1, 8'h80, 0, 1, 0, 0, 0, "R12 set beats w1 clear");
    fast = 0;
    step(4'd9, 0, 8'h00, 1, 0, 0, 0, 0, "R5 result read without fast clear");
    fast = 1;
    step(4'd7, 0, 8'h00, 1, 0, 0, 0, 0, "R5 unmapped read no clear");
    step(4'd9, 0, 8'h00, 1, 0, 0, 0, 0, "R5 fast clear on result read");
    step(4'd0, 0, 8'h00, 0, 1, 0, 0, 0, "R2 set");
    step(4'd5, 1, 8'h00, 0, 0, 0, 0, 0, "R4 start clears");

    busy = 1; edge_m = 0;
    step(4'd0, 0, 8'h00, 0, 0, 0, 1, 0, "R6 level mode no overrun");
    edge_m = 1; busy = 0;
    step(4'd0, 0, 8'h00, 0, 0, 0, 1, 0, "R6 idle no overrun");
    busy = 1;
    step(4'd0, 0, 8'h00, 0, 0, 0, 1, 0, "R6 overrun set");
    step(4'd6, 1, 8'h00, 0, 0, 0, 0, 0, "R9 write 0 no effect");
    step(4'd6, 1, 8'h20, 0, 0, 0, 0, 0, "R7 w1 clears overrun");
    step(4'd0, 0, 8'h00, 0, 0, 0, 1, 0, "R6 set");
    step(4'd2, 1, 8'h00, 0, 0, 0, 0, 0, "R7 ctrl write clears");
    step(4'd0, 0, 8'h00, 0, 0, 0, 1, 0, "R6 set");
    step(4'd5, 1, 8'h00, 0, 0, 0, 0, 0, "R7 start clears");
    step(4'd4, 1, 8'h00, 0, 0, 0, 1, 0, "R12 overrun set beats abort");

    step(4'd0, 0, 8'h00, 0, 0, 0, 0, 1, "R8 fifo overrun sets");
    step(4'd6, 1, 8'h10, 0, 0, 0, 0, 0, "R8 w1 clears");
    step(4'd0, 0, 8'h00, 0, 0, 0, 0, 1, "R8 set");
    step(4'd5, 1, 8'h00, 0, 0, 0, 0, 0, "R8 start clears");

    slen = 4'd3;
    for (int i = 0; i < 4; i++)
      step(4'd7, 0, 8'h00, 0, 0, 1, 0, 0, "R10 count wraps at 3");
    step(4'd6, 1, 8'hFF, 0, 0, 0, 0, 0, "R9 status write keeps counter");
    step(4'd1, 1, 8'h00, 0, 0, 1, 0, 0, "R11 abort beats increment");
    slen = 4'd0;
    for (int i = 0; i < 17; i++)
      step(4'd7, 0, 8'h00, 0, 0, 1, 0, 0, "R10 full 16 wrap");
    step(4'd5, 1, 8'h00, 0, 0, 0, 0, 0, "R11 start zeroes counter");

    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) begin
        fast = 1'($urandom); edge_m = 1'($urandom);
        slen = 4'($urandom);
      end
      busy = 1'($urandom);
      step(4'($urandom), ($urandom_range(0, 3) == 0), 8'($urandom),
           1'($urandom), ($urandom_range(0, 5) == 0), ($urandom_range(0, 2) == 0),
           ($urandom_range(0, 4) == 0), ($urandom_range(0, 7) == 0),
           "R12 random mix");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule